// File: doc/BRIEF.md
# Dual Word Queue with Request Triggers

This block sits between a register bus and a serial bus engine and holds two queues of 32-bit words. Software fills the outbound queue through a data register, and the engine drains it through a pop port. The engine fills the inbound queue through a push port, and software drains it by reading a data register. Each word carries four bus bytes. The first byte on the bus is the least significant byte of the word.

A single status word reports how many outbound slots are free and how many inbound words are waiting. Two request conditions compare these levels against trigger fields that software programs. Sticky error and event bits are collected in an interrupt status register, where writing a one clears a bit. A mask register selects which status bits drive the interrupt line. The packet-complete event reaches the line whatever its mask bit holds. Each queue can be emptied by a flush command, and the flush bit clears itself when the flush is done.

Register map on `csr_addr`: 0 outbound data (write pushes), 1 inbound data (read pops), 2 control, 3 level status, 4 interrupt mask, 5 interrupt status.

Top module: `wfifo_pair`

## Requirements
- R1: After reset both queues are empty, control and mask read 0, the level status reads 0x80, the interrupt status reads 0x02 and `irq` is low.
- R2: Words leave each queue in the order they entered, unchanged. Bits 7:0 of a word hold the first bus byte.
- R3: The level status word holds the outbound free-slot count in bits 7:4 and the inbound filled-word count in bits 3:0.
- R4: A write to the outbound data register while that queue holds 8 words is dropped, and it sets status bit 5 (outbound overflow).
- R5: A read of the inbound data register while that queue is empty returns 0, and it sets status bit 4 (inbound underflow).
- R6: Control bit 1 flushes the outbound queue and bit 0 flushes the inbound queue. A flush bit reads 1 in the cycle after the write and 0 one cycle later, and by then the queue is empty.
- R7: Control bits 7:5 hold the outbound trigger T and bits 4:2 hold the inbound trigger U. Status bit 1 (outbound request) is set while the free slots exceed T. Status bit 0 (inbound request) is set while the filled words exceed U.
- R8: Status bits 1:0 are level conditions evaluated every cycle. Writing ones to them has no effect while their condition holds.
- R9: Status bits 2 (arbitration lost), 3 (no acknowledge), 6 (all packets complete) and 7 (packet complete) are set by one-cycle event inputs. Writing a one clears a bit 7:2 and writing a zero keeps it. An event that arrives in the same cycle as the clear of its bit leaves the bit set.
- R10: `irq` is high when any status bit is set together with its mask bit, or when status bit 7 is set.
- R11: An engine push into a full inbound queue is dropped and leaves the stored words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr | input | 1 | Register write strobe |
| csr_rd | input | 1 | Register read strobe (pops when addressing inbound data) |
| csr_addr | input | 3 | Register index |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data, combinational |
| eng_tx_data | output | 32 | Head word of the outbound queue |
| eng_tx_avail | output | 1 | Outbound queue not empty |
| eng_tx_pop | input | 1 | Engine takes the head outbound word |
| eng_rx_data | input | 32 | Word from engine |
| eng_rx_push | input | 1 | Engine delivers a word |
| ev_arb_lost | input | 1 | Arbitration lost event |
| ev_nack | input | 1 | No acknowledge event |
| ev_all_done | input | 1 | All packets complete event |
| ev_pkt_done | input | 1 | Packet complete event |
| irq | output | 1 | Interrupt request |

## Verification
A software clear of a sticky status bit and a hardware event that sets the same bit can land on the same clock edge. The bench drives `ev_pkt_done` during the same cycle as a write-one to the status register that also clears the overflow bit. It expects bit 7 to survive while bit 5 drops, and it expects `irq` to stay high through the unmasked path. A second collision is tested as well: a write-one to the level-driven request bits while their condition still holds. The bench expects that write to change nothing.

// File: rtl/wfifo_pair.sv
module wfifo_pair #(
  parameter int DEPTH = 8,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          csr_wr,
  input  logic          csr_rd,
  input  logic [2:0]    csr_addr,
  input  logic [DW-1:0] csr_wdata,
  output logic [DW-1:0] csr_rdata,
  output logic [DW-1:0] eng_tx_data,
  output logic          eng_tx_avail,
  input  logic          eng_tx_pop,
  input  logic [DW-1:0] eng_rx_data,
  input  logic          eng_rx_push,
  input  logic          ev_arb_lost,
  input  logic          ev_nack,
  input  logic          ev_all_done,
  input  logic          ev_pkt_done,
  output logic          irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [2:0] A_TXD = 3'd0, A_RXD = 3'd1, A_CTRL = 3'd2,
                         A_LVL = 3'd3, A_MASK = 3'd4, A_IST = 3'd5;

  logic [DW-1:0] tx_mem [DEPTH];
  logic [DW-1:0] rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt, tx_free;
  logic [2:0]    trig_tx, trig_rx;
  logic          fl_tx, fl_rx;
  logic [7:0]    mask;
  logic [7:2]    st;
  logic [7:0]    istat;

  wire wr_txd  = csr_wr && csr_addr == A_TXD;
  wire wr_ctrl = csr_wr && csr_addr == A_CTRL;
  wire wr_ist  = csr_wr && csr_addr == A_IST;
  wire rd_rxd  = csr_rd && csr_addr == A_RXD;

  wire tx_full  = tx_cnt == CW'(DEPTH);
  wire rx_full  = rx_cnt == CW'(DEPTH);
  wire tx_push  = wr_txd && !tx_full;
  wire tx_ovf   = wr_txd && tx_full;
  wire tx_pop   = eng_tx_pop && tx_cnt != '0;
  wire rx_push  = eng_rx_push && !rx_full;
  wire rx_pop   = rd_rxd && rx_cnt != '0;
  wire rx_udf   = rd_rxd && rx_cnt == '0;

  assign tx_free      = CW'(DEPTH) - tx_cnt;
  assign eng_tx_avail = tx_cnt != '0;
  assign eng_tx_data  = tx_mem[tx_rp];

  wire tx_req = tx_free > CW'(trig_tx);
  wire rx_req = rx_cnt  > CW'(trig_rx);
  assign istat = {st, tx_req, rx_req};
  assign irq   = |(istat & mask) | st[7];

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= csr_wdata;
    if (rx_push) rx_mem[rx_wp] <= eng_rx_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || fl_tx) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || fl_rx) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_tx <= '0; trig_rx <= '0; fl_tx <= 1'b0; fl_rx <= 1'b0; mask <= '0;
    end else begin
      fl_tx <= wr_ctrl && csr_wdata[1];
      fl_rx <= wr_ctrl && csr_wdata[0];
      if (wr_ctrl) begin
        trig_tx <= csr_wdata[7:5];
        trig_rx <= csr_wdata[4:2];
      end
      if (csr_wr && csr_addr == A_MASK) mask <= csr_wdata[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= '0;
    else st <= (st & ~(wr_ist ? csr_wdata[7:2] : 6'd0))
             | {ev_pkt_done, ev_all_done, tx_ovf, rx_udf, ev_nack, ev_arb_lost};
  end

  always_comb begin
    csr_rdata = '0;
    case (csr_addr)
      A_RXD:  csr_rdata = (rx_cnt != '0) ? rx_mem[rx_rp] : '0;
      A_CTRL: csr_rdata[7:0] = {trig_tx, trig_rx, fl_tx, fl_rx};
      A_LVL:  csr_rdata[7:0] = {4'(tx_free), 4'(rx_cnt)};
      A_MASK: csr_rdata[7:0] = mask;
      A_IST:  csr_rdata[7:0] = istat;
      default: csr_rdata = '0;
    endcase
  end

  AST_TX_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && csr_addr == A_TXD && tx_full && !fl_tx) |=> istat[5]); // R4
  AST_UFLOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rd && csr_addr == A_RXD && rx_cnt == '0) |-> csr_rdata == '0); // R5
  AST_FLUSH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_tx && !(wr_ctrl && csr_wdata[1])) |=> (!fl_tx && tx_cnt == '0)); // R6
  AST_PKT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    st[7] |-> irq); // R10
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pkt_done |=> istat[7]); // R9
  AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && eng_rx_push && !rd_rxd && !fl_rx) |=> rx_full); // R11
endmodule

// File: tb/wfifo_pair_test.sv
module wfifo_pair_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_TXD = 3'd0, A_RXD = 3'd1, A_CTRL = 3'd2,
                         A_LVL = 3'd3, A_MASK = 3'd4, A_IST = 3'd5;
  localparam int NV = 10;
  // {is_read, addr, wdata, expected}
  localparam logic [67:0] VEC [NV] = '{
    {1'b0, A_TXD,  32'h11223344, 32'h0},
    {1'b0, A_TXD,  32'hA5A50001, 32'h0},
    {1'b1, A_LVL,  32'h0,        32'h60},
    {1'b0, A_CTRL, 32'hE0,       32'h0},
    {1'b1, A_IST,  32'h0,        32'h00},
    {1'b1, A_CTRL, 32'h0,        32'hE0},
    {1'b0, A_CTRL, 32'h04,       32'h0},
    {1'b1, A_IST,  32'h0,        32'h02},
    {1'b0, A_MASK, 32'h02,       32'h0},
    {1'b1, A_MASK, 32'h0,        32'h02}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic csr_wr = 1'b0, csr_rd = 1'b0;
  logic [2:0] csr_addr = '0;
  logic [31:0] csr_wdata = '0, csr_rdata, eng_tx_data, eng_rx_data = '0;
  logic eng_tx_avail, eng_tx_pop = 1'b0, eng_rx_push = 1'b0;
  logic ev_arb_lost = 1'b0, ev_nack = 1'b0, ev_all_done = 1'b0, ev_pkt_done = 1'b0;
  logic irq;
  int n_chk = 0, n_bad = 0;

  wfifo_pair uut (.clk, .rst_n, .csr_wr, .csr_rd, .csr_addr, .csr_wdata, .csr_rdata,
    .eng_tx_data, .eng_tx_avail, .eng_tx_pop, .eng_rx_data, .eng_rx_push,
    .ev_arb_lost, .ev_nack, .ev_all_done, .ev_pkt_done, .irq);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk); csr_wr = 1'b0;
  endtask

  task automatic peek(logic [2:0] a, output logic [31:0] d);
    csr_addr = a; #1; d = csr_rdata;
  endtask

  task automatic pop_rx(output logic [31:0] d);
    @(negedge clk); csr_rd = 1'b1; csr_addr = A_RXD; #1; d = csr_rdata;
    @(negedge clk); csr_rd = 1'b0;
  endtask

  task automatic push_rx(logic [31:0] d);
    @(negedge clk); eng_rx_push = 1'b1; eng_rx_data = d;
    @(negedge clk); eng_rx_push = 1'b0;
  endtask

  task automatic pop_tx(output logic [31:0] d);
    @(negedge clk); #1; d = eng_tx_data; eng_tx_pop = 1'b1;
    @(negedge clk); eng_tx_pop = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    peek(A_LVL, v);  check("R1 level", v, 32'h80);
    peek(A_IST, v);  check("R1 status", v, 32'h02);
    peek(A_CTRL, v); check("R1 ctrl", v, 32'h0);
    peek(A_MASK, v); check("R1 mask", v, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 tx avail", {31'b0, eng_tx_avail}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][67]) begin
        @(negedge clk); peek(VEC[i][66:64], v);
        check($sformatf("R3 R7 vector %0d", i), v, VEC[i][31:0]);
      end else wr(VEC[i][66:64], VEC[i][63:32]);
    end
    #1; check("R10 masked tx request", {31'b0, irq}, 32'h1);
    wr(A_MASK, 32'h0); #1;
    check("R10 mask off", {31'b0, irq}, 32'h0);

    pop_tx(v); check("R2 tx head", v, 32'h11223344);
    check("R2 first byte", {24'b0, v[7:0]}, 32'h44);
    pop_tx(v); check("R2 tx second", v, 32'hA5A50001);
    #1; check("R2 tx drained", {31'b0, eng_tx_avail}, 32'h0);

    push_rx(32'hDEADBEEF);
    peek(A_IST, v); check("R7 rx below trigger", {31'b0, v[0]}, 32'h0);
    push_rx(32'h01020304);
    peek(A_IST, v); check("R7 rx above trigger", {31'b0, v[0]}, 32'h1);
    peek(A_LVL, v); check("R3 level both", v, 32'h82);
    wr(A_IST, 32'h03);
    peek(A_IST, v); check("R8 level bits survive clear", {30'b0, v[1:0]}, 32'h3);
    pop_rx(v); check("R2 rx head", v, 32'hDEADBEEF);
    pop_rx(v); check("R2 rx second", v, 32'h01020304);
    pop_rx(v); check("R5 underflow data", v, 32'h0);
    peek(A_IST, v); check("R5 underflow flag", {31'b0, v[4]}, 32'h1);
    wr(A_IST, 32'h10);
    peek(A_IST, v); check("R9 w1c clears", {31'b0, v[4]}, 32'h0);

    for (int i = 0; i < 8; i++) wr(A_TXD, 32'h100 + i);
    peek(A_LVL, v); check("R3 tx full level", v, 32'h00);
    peek(A_IST, v); check("R7 no tx request when full", {31'b0, v[1]}, 32'h0);
    wr(A_TXD, 32'hBAD);
    peek(A_IST, v); check("R4 overflow flag", {31'b0, v[5]}, 32'h1);
    pop_tx(v); check("R4 head kept", v, 32'h100);
    for (int i = 1; i < 8; i++) pop_tx(v);
    check("R4 last stored", v, 32'h107);
    #1; check("R4 dropped word absent", {31'b0, eng_tx_avail}, 32'h0);

    for (int i = 0; i < 3; i++) wr(A_TXD, 32'h200 + i);
    push_rx(32'h55); push_rx(32'h66);
    wr(A_CTRL, 32'h03);
    peek(A_CTRL, v); check("R6 flush pending", v, 32'h03);
    @(negedge clk);
    peek(A_CTRL, v); check("R6 flush self clear", v, 32'h00);
    peek(A_LVL, v);  check("R6 queues empty", v, 32'h80);

    for (int i = 0; i < 9; i++) push_rx(32'h300 + i);
    peek(A_LVL, v); check("R11 rx full level", v, 32'h88);
    for (int i = 0; i < 8; i++) pop_rx(v);
    check("R11 last stored kept", v, 32'h307);
    peek(A_LVL, v); check("R11 nothing extra", v, 32'h80);

    @(negedge clk);
    csr_wr = 1'b1; csr_addr = A_IST; csr_wdata = 32'hFC; ev_pkt_done = 1'b1;
    @(negedge clk);
    csr_wr = 1'b0; ev_pkt_done = 1'b0;
    peek(A_IST, v);
    check("R9 event beats clear", {31'b0, v[7]}, 32'h1);
    check("R9 other bit cleared", {31'b0, v[5]}, 32'h0);
    check("R10 packet done unmasked", {31'b0, irq}, 32'h1);
    wr(A_IST, 32'h80);
    peek(A_IST, v); check("R9 packet done cleared", {31'b0, v[7]}, 32'h0);
    check("R10 irq drops", {31'b0, irq}, 32'h0);

    @(negedge clk); ev_nack = 1'b1; @(negedge clk); ev_nack = 1'b0;
    peek(A_IST, v); check("R9 nack sets", {31'b0, v[3]}, 32'h1);
    check("R10 nack masked", {31'b0, irq}, 32'h0);
    wr(A_MASK, 32'h08); #1;
    check("R10 nack unmasked", {31'b0, irq}, 32'h1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule